// File: doc/BRIEF.md
# Segmented Address Generation Unit

The unit forms operand addresses for a segmented 32-bit processor. Each request names an optional base register, an optional index register with a scale, and a displacement of one of several widths. The unit adds these into an effective address. From the kind of memory reference and the base register it picks a segment, and it honours a segment override only for ordinary data references. It then adds that segment's base to give the linear address.

A flag selects 16-bit addressing. In that mode only a small set of registers is legal, scaling is off and the effective address wraps at 64 KiB. An illegal register choice sets an error flag and forces both address outputs to zero. All results are captured in one output register stage. A request presented with `valid_in` high has its results on the outputs one clock later.

Top module: `addr_gen_unit`

## Requirements
- R1: In 32-bit mode, `ea_out` = base + scaled index + displacement, modulo 2^32. A term whose enable is low (or `disp_size` = 0) counts as zero. `disp_size` encodes 0 = none, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit, and 8-bit and 16-bit displacements are sign-extended. Register codes are 0 EAX, 1 ECX, 2 EDX, 3 EBX, 4 ESP, 5 EBP, 6 ESI, 7 EDI, and register n occupies bits [32n+31:32n] of `gpr_flat`.
- R2: In 32-bit mode, `scale` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. For a data reference (`ref_kind` = 0) with no override, the segment is SS when the base is EBP or ESP and DS otherwise. This includes the case with no base.
- R4: `ref_kind` 1 (code fetch) always gives CS, 2 (stack push or pop) always gives SS, and 3 (string-store destination) always gives ES, whatever the override inputs hold.
- R5: For a data reference with `ovr_en` high, an `ovr_seg` of 0 to 5 selects that segment. Codes 6 and 7 are ignored and the default applies.
- R6: With `addr16` high, the unit uses the low 16 bits of base and index and ignores `scale`. A displacement is sign-extended, or for 32-bit truncated, to 16 bits. `ea_out` is the 16-bit sum with bits 31:16 zero.
- R7: With `addr16` high, only EBX (3) or EBP (5) may be base and only ESI (6) or EDI (7) may be index. Any other enabled choice sets `err_out`.
- R8: With `addr16` low, an enabled index of ESP (4) sets `err_out`. ESP as base is legal.
- R9: When `err_out` is high, `ea_out` and `lin_out` are zero.
- R10: When no error occurs, `lin_out` = base of the selected segment + `ea_out`, modulo 2^32. Segment s occupies bits [32s+31:32s] of `seg_base_flat`.
- R11: `valid_out` is `valid_in` delayed by one clock, and results appear in that same cycle. While `valid_in` is low, the address, segment and error outputs hold their values.
- R12: Synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Request present this cycle |
| gpr_flat | input | 256 | Eight 32-bit general registers, packed |
| seg_base_flat | input | 192 | Six 32-bit segment bases, packed |
| base_en | input | 1 | Base term used |
| base_sel | input | 3 | Base register code |
| index_en | input | 1 | Index term used |
| index_sel | input | 3 | Index register code |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Displacement bits |
| disp_size | input | 2 | Displacement width code |
| ref_kind | input | 2 | Reference type |
| ovr_en | input | 1 | Override prefix present |
| ovr_seg | input | 3 | Override segment code |
| addr16 | input | 1 | 16-bit addressing |
| valid_out | output | 1 | Results valid |
| ea_out | output | 32 | Effective address |
| seg_out | output | 3 | Selected segment code |
| lin_out | output | 32 | Linear address |
| err_out | output | 1 | Illegal register choice |

## Verification
The checker assumes that each output cycle follows a request whose inputs it can see one clock earlier through `$past`. This holds because the design has exactly one register stage and the bench holds all request fields steady from one falling edge to the next. The linear-address property relies on the segment bases staying steady across a request, and the bench fixes them before reset and never changes them. The bench drives only the defined codes of `ref_kind` and `disp_size`, and it drives the reserved override codes 6 and 7 only for the case that R5 calls out.

// File: rtl/agu_pkg.sv
// Shared encodings for the address generation unit.
// Assumes eight general registers and six segment registers.
package agu_pkg;
    localparam int GPR_W = 3;
    localparam int SEG_W = 3;

    localparam logic [GPR_W-1:0] GPR_EBX = 3'd3;
    localparam logic [GPR_W-1:0] GPR_ESP = 3'd4;
    localparam logic [GPR_W-1:0] GPR_EBP = 3'd5;
    localparam logic [GPR_W-1:0] GPR_ESI = 3'd6;
    localparam logic [GPR_W-1:0] GPR_EDI = 3'd7;

    localparam logic [SEG_W-1:0] SEG_ES  = 3'd0;
    localparam logic [SEG_W-1:0] SEG_CS  = 3'd1;
    localparam logic [SEG_W-1:0] SEG_SS  = 3'd2;
    localparam logic [SEG_W-1:0] SEG_DS  = 3'd3;
    localparam logic [SEG_W-1:0] SEG_GS  = 3'd5;

    localparam logic [1:0] REF_DATA   = 2'd0;
    localparam logic [1:0] REF_CODE   = 2'd1;
    localparam logic [1:0] REF_STACK  = 2'd2;
    localparam logic [1:0] REF_STRDST = 2'd3;

    localparam logic [1:0] DSZ_NONE = 2'd0;
    localparam logic [1:0] DSZ_8    = 2'd1;
    localparam logic [1:0] DSZ_16   = 2'd2;
endpackage

// File: rtl/agu_ea_calc.sv
// Effective address adder: base + scaled index + sign-extended displacement.
// Assumes DATA_W >= 16; in 16-bit mode the sum is cut to 16 bits and scaling is off.
module agu_ea_calc #(
    parameter int DATA_W   = 32,
    parameter int NUM_GPR  = 8,
    localparam int SEL_W   = $clog2(NUM_GPR)
) (
    input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
    input  logic                      base_en,
    input  logic [SEL_W-1:0]          base_sel,
    input  logic                      index_en,
    input  logic [SEL_W-1:0]          index_sel,
    input  logic [1:0]                scale,
    input  logic [DATA_W-1:0]         disp,
    input  logic [1:0]                disp_size,
    input  logic                      addr16,
    output logic [DATA_W-1:0]         ea
);
    import agu_pkg::*;

    logic [DATA_W-1:0] base_v, idx_v, scaled_v, disp_x, sum_v;

    // Select terms, extend displacement, add and wrap.
    always_comb begin
        base_v = base_en  ? gpr_flat[base_sel*DATA_W +: DATA_W]  : '0;
        idx_v  = index_en ? gpr_flat[index_sel*DATA_W +: DATA_W] : '0;
        case (disp_size)
            DSZ_NONE: disp_x = '0;
            DSZ_8:    disp_x = {{(DATA_W-8){disp[7]}}, disp[7:0]};
            DSZ_16:   disp_x = {{(DATA_W-16){disp[15]}}, disp[15:0]};
            default:  disp_x = disp;
        endcase
        scaled_v = addr16 ? idx_v : (idx_v << scale);
        sum_v    = base_v + scaled_v + disp_x;
        ea       = addr16 ? {{(DATA_W-16){1'b0}}, sum_v[15:0]} : sum_v;
    end
endmodule

// File: rtl/agu_reg_legal.sv
// Flags register choices that the active address size forbids.
// Assumes the fixed register codes of agu_pkg.
module agu_reg_legal (
    input  logic       base_en,
    input  logic [2:0] base_sel,
    input  logic       index_en,
    input  logic [2:0] index_sel,
    input  logic       addr16,
    output logic       illegal
);
    import agu_pkg::*;

    logic bad_base16, bad_idx16, bad_idx32;

    // Compare the chosen registers against the legal sets of each mode.
    always_comb begin
        bad_base16 = base_en  && (base_sel != GPR_EBX) && (base_sel != GPR_EBP);
        bad_idx16  = index_en && (index_sel != GPR_ESI) && (index_sel != GPR_EDI);
        bad_idx32  = index_en && (index_sel == GPR_ESP);
        illegal    = addr16 ? (bad_base16 || bad_idx16) : bad_idx32;
    end
endmodule

// File: rtl/agu_seg_sel.sv
// Chooses the segment from reference type, base register and override.
// Assumes override codes above GS are not real segments and are ignored.
module agu_seg_sel (
    input  logic [1:0] ref_kind,
    input  logic       base_en,
    input  logic [2:0] base_sel,
    input  logic       ovr_en,
    input  logic [2:0] ovr_seg,
    output logic [2:0] seg
);
    import agu_pkg::*;

    logic [2:0] data_dflt;

    // Fixed segment for non-data kinds, default or override for data.
    always_comb begin
        data_dflt = (base_en && (base_sel == GPR_ESP || base_sel == GPR_EBP)) ? SEG_SS : SEG_DS;
        case (ref_kind)
            REF_CODE:   seg = SEG_CS;
            REF_STACK:  seg = SEG_SS;
            REF_STRDST: seg = SEG_ES;
            default:    seg = (ovr_en && ovr_seg <= SEG_GS) ? ovr_seg : data_dflt;
        endcase
    end
endmodule

// File: rtl/addr_gen_unit.sv
// Top of the address generation unit: effective address, segment choice,
// linear address, one output register stage.
// Assumes seg_base_flat holds one base per segment code 0..NUM_SEG-1.
module addr_gen_unit #(
    parameter int DATA_W  = 32,
    parameter int NUM_GPR = 8,
    parameter int NUM_SEG = 6,
    localparam int SEL_W  = $clog2(NUM_GPR),
    localparam int SEGC_W = $clog2(NUM_SEG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_in,
    input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
    input  logic [NUM_SEG*DATA_W-1:0] seg_base_flat,
    input  logic                      base_en,
    input  logic [SEL_W-1:0]          base_sel,
    input  logic                      index_en,
    input  logic [SEL_W-1:0]          index_sel,
    input  logic [1:0]                scale,
    input  logic [DATA_W-1:0]         disp,
    input  logic [1:0]                disp_size,
    input  logic [1:0]                ref_kind,
    input  logic                      ovr_en,
    input  logic [SEGC_W-1:0]         ovr_seg,
    input  logic                      addr16,
    output logic                      valid_out,
    output logic [DATA_W-1:0]         ea_out,
    output logic [SEGC_W-1:0]         seg_out,
    output logic [DATA_W-1:0]         lin_out,
    output logic                      err_out
);
    logic [DATA_W-1:0] ea_c, lin_c;
    logic [SEGC_W-1:0] seg_c;
    logic              illegal_c;

    agu_ea_calc #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_ea (
        .gpr_flat(gpr_flat), .base_en(base_en), .base_sel(base_sel),
        .index_en(index_en), .index_sel(index_sel), .scale(scale),
        .disp(disp), .disp_size(disp_size), .addr16(addr16), .ea(ea_c)
    );

    agu_reg_legal u_legal (
        .base_en(base_en), .base_sel(base_sel), .index_en(index_en),
        .index_sel(index_sel), .addr16(addr16), .illegal(illegal_c)
    );

    agu_seg_sel u_seg (
        .ref_kind(ref_kind), .base_en(base_en), .base_sel(base_sel),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg(seg_c)
    );

    // Add the chosen segment base to the effective address.
    always_comb lin_c = seg_base_flat[seg_c*DATA_W +: DATA_W] + ea_c;

    // Output stage: capture on a request, zero addresses on error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            ea_out    <= '0;
            seg_out   <= '0;
            lin_out   <= '0;
            err_out   <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                ea_out  <= illegal_c ? '0 : ea_c;
                lin_out <= illegal_c ? '0 : lin_c;
                seg_out <= seg_c;
                err_out <= illegal_c;
            end
        end
    end
endmodule

// File: rtl/agu_checker.sv
// Temporal checks on the address generation unit ports, bound to the top.
module agu_checker #(
    parameter int DATA_W  = 32,
    parameter int NUM_SEG = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      valid_in,
    input logic [NUM_SEG*DATA_W-1:0] seg_base_flat,
    input logic                      index_en,
    input logic [2:0]                index_sel,
    input logic [1:0]                ref_kind,
    input logic                      addr16,
    input logic                      valid_out,
    input logic [DATA_W-1:0]         ea_out,
    input logic [2:0]                seg_out,
    input logic [DATA_W-1:0]         lin_out,
    input logic                      err_out
);
    logic [NUM_SEG*DATA_W-1:0] sb_prev;

    // Keep last cycle's segment bases to match the registered outputs.
    always_ff @(posedge clk) sb_prev <= seg_base_flat;

    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && err_out |-> ea_out == '0 && lin_out == '0); // R9
    AST_ESP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && $past(index_en && index_sel == 3'd4 && !addr16) |-> err_out); // R8
    AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && $past(addr16) |-> ea_out[DATA_W-1:16] == '0); // R6
    AST_FIXED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && $past(ref_kind) == 2'd1 |-> seg_out == 3'd1); // R4
    AST_FIXED_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && $past(ref_kind) == 2'd2 |-> seg_out == 3'd2); // R4
    AST_FIXED_STRDST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && $past(ref_kind) == 2'd3 |-> seg_out == 3'd0); // R4
    AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> seg_out <= 3'd5); // R5
    AST_LIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && !err_out |-> lin_out == sb_prev[seg_out*DATA_W +: DATA_W] + ea_out); // R10
    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R11
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(ea_out) && $stable(lin_out) && $stable(seg_out)); // R11
endmodule

bind addr_gen_unit agu_checker #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) u_agu_checker (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .seg_base_flat(seg_base_flat),
    .index_en(index_en), .index_sel(index_sel), .ref_kind(ref_kind), .addr16(addr16),
    .valid_out(valid_out), .ea_out(ea_out), .seg_out(seg_out), .lin_out(lin_out),
    .err_out(err_out)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in;
    logic [255:0] gpr_flat;
    logic [191:0] seg_base_flat;
    logic        base_en, index_en, ovr_en, addr16;
    logic [2:0]  base_sel, index_sel, ovr_seg;
    logic [1:0]  scale, disp_size, ref_kind;
    logic [31:0] disp;
    logic        valid_out, err_out;
    logic [31:0] ea_out, lin_out;
    logic [2:0]  seg_out;

    logic [31:0] g [8];
    logic [31:0] sb [6];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    addr_gen_unit i_addr_gen_unit (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .gpr_flat(gpr_flat),
        .seg_base_flat(seg_base_flat), .base_en(base_en), .base_sel(base_sel),
        .index_en(index_en), .index_sel(index_sel), .scale(scale), .disp(disp),
        .disp_size(disp_size), .ref_kind(ref_kind), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .addr16(addr16), .valid_out(valid_out), .ea_out(ea_out), .seg_out(seg_out),
        .lin_out(lin_out), .err_out(err_out)
    );

    always_comb begin
        for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = g[i];
        for (int k = 0; k < 6; k++) seg_base_flat[k*32 +: 32] = sb[k];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        valid_in = 1'b1; base_en = 0; base_sel = 0; index_en = 0; index_sel = 0;
        scale = 0; disp = 0; disp_size = 0; ref_kind = 0; ovr_en = 0; ovr_seg = 0;
        addr16 = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 valid", {31'b0, valid_out}, 0);
        chk("R12 ea", ea_out, 0);
        chk("R12 lin", lin_out, 0);
        chk("R12 seg/err", {28'b0, seg_out, err_out}, 0);
    endtask

    task automatic t_ea32();
        clr(); base_en = 1; base_sel = 3; disp = 32'h100; disp_size = 3; step();
        chk("R1 base+disp32", ea_out, g[3] + 32'h100);
        chk("R11 valid lag", {31'b0, valid_out}, 1);
        clr(); base_en = 1; base_sel = 3; index_en = 1; index_sel = 6;
        disp = 32'hABCD_12F0; disp_size = 1; step();
        chk("R1 base+index+disp8 neg", ea_out, g[3] + g[6] - 32'd16);
        clr(); disp = 32'h0000_8000; disp_size = 2; step();
        chk("R1 disp16 only sign-ext", ea_out, 32'hFFFF_8000);
        clr(); base_en = 1; base_sel = 2; disp = 32'h20; disp_size = 0; step();
        chk("R1 disp size none", ea_out, g[2]);
    endtask

    task automatic t_scale();
        for (int sc = 0; sc < 4; sc++) begin
            clr(); index_en = 1; index_sel = 1; scale = 2'(sc); step();
            chk("R2 scale", ea_out, g[1] << sc);
        end
    endtask

    task automatic t_default_seg();
        clr(); base_en = 1; base_sel = 5; step();
        chk("R3 EBP base", {29'b0, seg_out}, 2);
        clr(); base_en = 1; base_sel = 4; step();
        chk("R3 ESP base", {29'b0, seg_out}, 2);
        clr(); base_en = 1; base_sel = 0; index_en = 1; index_sel = 5; step();
        chk("R3 EAX base, EBP index", {29'b0, seg_out}, 3);
        clr(); disp = 32'h40; disp_size = 3; step();
        chk("R3 no base", {29'b0, seg_out}, 3);
    endtask

    task automatic t_fixed_kinds();
        clr(); ref_kind = 1; ovr_en = 1; ovr_seg = 4; step();
        chk("R4 code ignores override", {29'b0, seg_out}, 1);
        clr(); ref_kind = 2; base_en = 1; base_sel = 0; ovr_en = 1; ovr_seg = 0; step();
        chk("R4 stack ignores override", {29'b0, seg_out}, 2);
        clr(); ref_kind = 3; base_en = 1; base_sel = 7; ovr_en = 1; ovr_seg = 5; step();
        chk("R4 string dest ignores override", {29'b0, seg_out}, 0);
    endtask

    task automatic t_override();
        clr(); base_en = 1; base_sel = 5; ovr_en = 1; ovr_seg = 4; step();
        chk("R5 override FS", {29'b0, seg_out}, 4);
        chk("R10 linear via FS", lin_out, sb[4] + g[5]);
        clr(); base_en = 1; base_sel = 5; ovr_en = 1; ovr_seg = 6; step();
        chk("R5 code 6 ignored", {29'b0, seg_out}, 2);
        clr(); base_en = 1; base_sel = 3; ovr_en = 1; ovr_seg = 0; step();
        chk("R5 override ES", {29'b0, seg_out}, 0);
    endtask

    task automatic t_addr16();
        clr(); addr16 = 1; base_en = 1; base_sel = 3; index_en = 1; index_sel = 6;
        scale = 3; disp = 32'h0000_00FF; disp_size = 1; step();
        chk("R6 BX+SI-1 no scale", ea_out, 32'h0000_811F);
        chk("R6 no error", {31'b0, err_out}, 0);
        clr(); addr16 = 1; base_en = 1; base_sel = 5; index_en = 1; index_sel = 7;
        disp = 32'h0000_0010; disp_size = 2; step();
        chk("R6 BP+DI wrap", ea_out, 32'h0000_F008);
        chk("R6 BP defaults SS", {29'b0, seg_out}, 2);
        chk("R10 linear 16", lin_out, sb[2] + 32'h0000_F008);
    endtask

    task automatic t_illegal16();
        clr(); addr16 = 1; base_en = 1; base_sel = 0; step();
        chk("R7 base EAX err", {31'b0, err_out}, 1);
        chk("R9 ea zero", ea_out, 0);
        chk("R9 lin zero", lin_out, 0);
        clr(); addr16 = 1; index_en = 1; index_sel = 3; step();
        chk("R7 index BX err", {31'b0, err_out}, 1);
        clr(); addr16 = 1; base_en = 1; base_sel = 6; step();
        chk("R7 base SI err", {31'b0, err_out}, 1);
    endtask

    task automatic t_esp();
        clr(); base_en = 1; base_sel = 3; index_en = 1; index_sel = 4; disp = 5; disp_size = 3; step();
        chk("R8 ESP index err", {31'b0, err_out}, 1);
        chk("R9 ea zero", ea_out, 0);
        clr(); base_en = 1; base_sel = 4; index_en = 1; index_sel = 0; step();
        chk("R8 ESP base ok", {31'b0, err_out}, 0);
        chk("R8 ESP base ea", ea_out, g[4] + g[0]);
    endtask

    task automatic t_linear();
        clr(); base_en = 1; base_sel = 0; disp = 32'hFFFF_F000; disp_size = 3;
        ovr_en = 1; ovr_seg = 5; step();
        chk("R1 wrap 2^32", ea_out, 32'h0);
        chk("R10 linear GS", lin_out, sb[5]);
    endtask

    task automatic t_hold();
        logic [31:0] ea_prev, lin_prev;
        clr(); base_en = 1; base_sel = 7; disp = 32'h44; disp_size = 3; step();
        ea_prev = ea_out; lin_prev = lin_out;
        clr(); valid_in = 0; base_sel = 1; index_en = 1; index_sel = 4; step(); step();
        chk("R11 valid low", {31'b0, valid_out}, 0);
        chk("R11 ea held", ea_out, ea_prev);
        chk("R11 lin held", lin_out, lin_prev);
        chk("R11 err held", {31'b0, err_out}, 0);
    endtask

    initial begin
        g[0] = 32'h0000_1000; g[1] = 32'h0000_2004; g[2] = 32'hFFFF_FFF0; g[3] = 32'h0001_8000;
        g[4] = 32'h0000_7FF0; g[5] = 32'h0002_FFF8; g[6] = 32'h0000_0120; g[7] = 32'h1234_F000;
        for (int k = 0; k < 6; k++) sb[k] = 32'h0010_0000 * (k + 1);
        clr(); valid_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ea32();
        t_scale();
        t_default_seg();
        t_fixed_kinds();
        t_override();
        t_addr16();
        t_illegal16();
        t_esp();
        t_linear();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule